// File: doc/BRIEF.md
# Dual-PLL Power Control Sequencer

This block decides, once per reference-clock cycle, whether each of two synthesiser loops (an RF loop and an IF loop) is running or powered down, and whether the shared reference oscillator may stop. Each loop has an asynchronous hardware enable pin and a power-down bit held in the serial register file. A low pin forces its loop down whatever the bit says. While the pin is high, the bit decides. A separate doubler-enable bit keeps the reference oscillator running even when both loops are down. The pins do not override this bit.

A powered-down loop gets four outputs. Its charge pump is placed in tri-state, its phase comparator is placed in tri-state, its input buffer is disabled, and its reference (R) and feedback (N) dividers are held in reset. Both divider resets rise in the cycle in which power-down takes effect. They fall together one reference-clock edge after power-down is removed, so the two dividers start counting from the same edge. The serial register port sits in an always-on domain and is not controlled by this block. Its bits arrive here already synchronous to the reference clock. The enable pins are asynchronous and pass through a two-flop synchroniser.

Top module: `dual_pll_pwr_seq`

## Requirements
- R1: While reset is asserted and after it is released, until inputs propagate, both loops are powered down, all divider resets are high and the oscillator disable is high.
- R2: Loop i (index 0 = RF loop, index 1 = IF loop) is powered down whenever its enable pin is low, regardless of its power-down bit.
- R3: While the enable pin of loop i is high, that loop is powered down exactly when its power-down bit is 1.
- R4: For a powered-down loop, the charge-pump tri-state, phase-comparator tri-state and input-buffer disable outputs are all 1. For a running loop they are all 0.
- R5: The oscillator disable is 1 exactly when both loops are powered down and the doubler-enable bit is 0.
- R6: With both enable pins low and the doubler-enable bit at 1, the oscillator disable stays 0.
- R7: The R and N divider resets of a loop are 1 in every cycle in which that loop is powered down.
- R8: When power-down of a loop is removed, its R and N divider resets fall together on the following reference-clock edge, not earlier.
- R9: A power-down bit change takes effect on the first rising clock edge after it. An enable pin change takes effect on the third rising edge. The doubler-enable bit affects the oscillator disable after one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pll_en_pin | input | 2 | Asynchronous enable pins, bit 0 RF loop, bit 1 IF loop |
| pll_pd_bit | input | 2 | Register power-down bits, synchronous to clk_ref |
| dbl_en | input | 1 | Doubler-enable register bit, keeps the oscillator running |
| cp_tri | output | 2 | Charge-pump tri-state per loop |
| pfd_tri | output | 2 | Phase-comparator tri-state per loop |
| fin_buf_dis | output | 2 | Input-buffer disable per loop |
| r_cnt_rst | output | 2 | Reference divider reset per loop |
| n_cnt_rst | output | 2 | Feedback divider reset per loop |
| osc_dis | output | 1 | Reference oscillator disable |

## Verification
The assertions assume that the register bits and the doubler bit are synchronous to clk_ref and never change within a cycle. They also assume that a pin counts as "held" only once it has kept one level over consecutive sampling edges. The pin rule is therefore checked with a run-length counter and not against a single sample. The stimulus changes every input only at the falling clock edge. It keeps each input pattern in place for four edges, which covers the synchroniser, the state register and the divider release, before the outputs are compared. Latency checks move one input at a time from a settled state.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  localparam int unsigned NUM_LOOPS = 2;
  localparam int unsigned RF_IDX    = 0;
  localparam int unsigned IF_IDX    = 1;

  typedef struct packed {
    logic cp_tri;
    logic pfd_tri;
    logic buf_dis;
    logic r_rst;
    logic n_rst;
  } loop_ctl_t;

  localparam loop_ctl_t LOOP_OFF = '{cp_tri: 1'b1, pfd_tri: 1'b1, buf_dis: 1'b1,
                                     r_rst: 1'b1, n_rst: 1'b1};
endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
  parameter int unsigned STAGES = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= RST_VAL;
          else        chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= RST_VAL;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pwr_loop_ctrl.sv
module pwr_loop_ctrl
  import pwr_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pin_ok,
  input  logic      pd_bit,
  output logic      pd_o,
  output loop_ctl_t ctl
);
  logic pd_q;
  logic rel_hold_q;
  logic cnt_rst;

  // Enable pin overrides; otherwise the register bit decides.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pd_q <= 1'b1;
    else        pd_q <= !pin_ok || pd_bit;
  end

  // Remembers last cycle's power state so the divider release trails by one edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rel_hold_q <= 1'b1;
    else        rel_hold_q <= pd_q;
  end

  assign cnt_rst = pd_q || rel_hold_q;

  always_comb begin
    ctl.cp_tri  = pd_q;
    ctl.pfd_tri = pd_q;
    ctl.buf_dis = pd_q;
    ctl.r_rst   = cnt_rst;
    ctl.n_rst   = cnt_rst;
  end

  assign pd_o = pd_q;
endmodule

// File: rtl/pwr_osc_ctrl.sv
module pwr_osc_ctrl #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] loop_pd,
  input  logic         dbl_en,
  output logic         osc_dis
);
  logic dbl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dbl_q <= 1'b0;
    else        dbl_q <= dbl_en;
  end

  assign osc_dis = (&loop_pd) && !dbl_q;
endmodule

// File: rtl/dual_pll_pwr_seq.sv
module dual_pll_pwr_seq
  import pwr_seq_pkg::*;
#(
  parameter int unsigned NLOOP       = NUM_LOOPS,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic [NLOOP-1:0] pll_en_pin,
  input  logic [NLOOP-1:0] pll_pd_bit,
  input  logic             dbl_en,
  output logic [NLOOP-1:0] cp_tri,
  output logic [NLOOP-1:0] pfd_tri,
  output logic [NLOOP-1:0] fin_buf_dis,
  output logic [NLOOP-1:0] r_cnt_rst,
  output logic [NLOOP-1:0] n_cnt_rst,
  output logic             osc_dis
);
  logic [NLOOP-1:0] pin_ok;
  logic [NLOOP-1:0] loop_pd;
  loop_ctl_t        ctl [NLOOP];

  generate
    for (genvar i = 0; i < NLOOP; i++) begin : g_loop
      pwr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
        .clk   (clk_ref),
        .rst_n (rst_n),
        .d     (pll_en_pin[i]),
        .q     (pin_ok[i])
      );

      pwr_loop_ctrl u_ctrl (
        .clk    (clk_ref),
        .rst_n  (rst_n),
        .pin_ok (pin_ok[i]),
        .pd_bit (pll_pd_bit[i]),
        .pd_o   (loop_pd[i]),
        .ctl    (ctl[i])
      );

      assign cp_tri[i]      = ctl[i].cp_tri;
      assign pfd_tri[i]     = ctl[i].pfd_tri;
      assign fin_buf_dis[i] = ctl[i].buf_dis;
      assign r_cnt_rst[i]   = ctl[i].r_rst;
      assign n_cnt_rst[i]   = ctl[i].n_rst;
    end
  endgenerate

  pwr_osc_ctrl #(.N(NLOOP)) u_osc (
    .clk     (clk_ref),
    .rst_n   (rst_n),
    .loop_pd (loop_pd),
    .dbl_en  (dbl_en),
    .osc_dis (osc_dis)
  );
endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk #(
  parameter int unsigned NLOOP       = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input logic             clk_ref,
  input logic             rst_n,
  input logic [NLOOP-1:0] pll_en_pin,
  input logic [NLOOP-1:0] pll_pd_bit,
  input logic             dbl_en,
  input logic [NLOOP-1:0] cp_tri,
  input logic [NLOOP-1:0] pfd_tri,
  input logic [NLOOP-1:0] fin_buf_dis,
  input logic [NLOOP-1:0] r_cnt_rst,
  input logic [NLOOP-1:0] n_cnt_rst,
  input logic             osc_dis
);
  localparam int unsigned PIN_LAT = SYNC_STAGES + 1;
  localparam int unsigned RUN_W   = $clog2(PIN_LAT + 1);

  logic live;
  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;
  end

  // R5/R6: oscillator follows both loop states and last cycle's doubler bit
  a_r5_osc_rule: assert property (@(posedge clk_ref) disable iff (!rst_n || !live)
    osc_dis == ((&cp_tri) && !$past(dbl_en)));

  generate
    for (genvar i = 0; i < NLOOP; i++) begin : g_chk
      logic [RUN_W-1:0] low_run;
      always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n)                  low_run <= '0;
        else if (pll_en_pin[i])      low_run <= '0;
        else if (low_run != PIN_LAT[RUN_W-1:0]) low_run <= low_run + 1'b1;
      end

      // R2: a pin held low long enough forces power-down
      a_r2_pin_forces: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (low_run == PIN_LAT[RUN_W-1:0]) |-> cp_tri[i]);

      // R3: a set register bit powers the loop down on the next edge
      a_r3_bit_forces: assert property (@(posedge clk_ref) disable iff (!rst_n || !live)
        $past(pll_pd_bit[i]) |-> cp_tri[i]);

      // R4: the three power-down controls move as one
      a_r4_group: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (cp_tri[i] == pfd_tri[i]) && (cp_tri[i] == fin_buf_dis[i]));

      // R7: dividers in reset whenever the loop is down
      a_r7_rst_in_pd: assert property (@(posedge clk_ref) disable iff (!rst_n)
        cp_tri[i] |-> (r_cnt_rst[i] && n_cnt_rst[i]));

      // R8: release together, one edge after power-down left
      a_r8_release: assert property (@(posedge clk_ref) disable iff (!rst_n || !live)
        $fell(r_cnt_rst[i]) |-> ($fell(n_cnt_rst[i]) && !cp_tri[i] && $past(!cp_tri[i])));

      a_r8_no_early: assert property (@(posedge clk_ref) disable iff (!rst_n || !live)
        $fell(cp_tri[i]) |-> (r_cnt_rst[i] && n_cnt_rst[i]));
    end
  endgenerate
endmodule

bind dual_pll_pwr_seq pwr_seq_chk #(.NLOOP(NLOOP), .SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk_ref     (clk_ref),
  .rst_n       (rst_n),
  .pll_en_pin  (pll_en_pin),
  .pll_pd_bit  (pll_pd_bit),
  .dbl_en      (dbl_en),
  .cp_tri      (cp_tri),
  .pfd_tri     (pfd_tri),
  .fin_buf_dis (fin_buf_dis),
  .r_cnt_rst   (r_cnt_rst),
  .n_cnt_rst   (n_cnt_rst),
  .osc_dis     (osc_dis)
);

// File: tb/dual_pll_pwr_seq_tb.sv
module dual_pll_pwr_seq_tb;
  logic       clk_ref = 1'b0;
  logic       rst_n   = 1'b0;
  logic [1:0] pll_en_pin = 2'b11;
  logic [1:0] pll_pd_bit = 2'b00;
  logic       dbl_en = 1'b0;
  logic [1:0] cp_tri, pfd_tri, fin_buf_dis, r_cnt_rst, n_cnt_rst;
  logic       osc_dis;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #5 clk_ref = ~clk_ref;

  dual_pll_pwr_seq u_dut (
    .clk_ref, .rst_n, .pll_en_pin, .pll_pd_bit, .dbl_en,
    .cp_tri, .pfd_tri, .fin_buf_dis, .r_cnt_rst, .n_cnt_rst, .osc_dis
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic settle_check(input string tag);
    logic [1:0] pd_exp;
    pd_exp = ~pll_en_pin | pll_pd_bit;
    chk({tag, " R2 R3 cp_tri"}, cp_tri, pd_exp);
    chk({tag, " R4 pfd_tri"}, pfd_tri, pd_exp);
    chk({tag, " R4 fin_buf_dis"}, fin_buf_dis, pd_exp);
    chk({tag, " R7 r_cnt_rst"}, r_cnt_rst, pd_exp);
    chk({tag, " R7 n_cnt_rst"}, n_cnt_rst, pd_exp);
    chk({tag, " R5 R6 osc_dis"}, osc_dis, (&pd_exp) & ~dbl_en);
  endtask

  initial begin
    repeat (3) @(negedge clk_ref);
    // R1: during reset
    chk("R1 cp_tri in reset", cp_tri, 2'b11);
    chk("R1 counter resets in reset", {r_cnt_rst, n_cnt_rst}, 4'hF);
    chk("R1 osc_dis in reset", osc_dis, 1'b1);
    rst_n = 1'b1;
    @(negedge clk_ref);
    chk("R1 after release pin sync pending", cp_tri, 2'b11);
    chk("R1 osc_dis after release", osc_dis, 1'b1);

    // Exhaustive sweep over pins, bits and doubler
    for (int v = 0; v < 32; v++) begin
      pll_en_pin = v[1:0];
      pll_pd_bit = v[3:2];
      dbl_en     = v[4];
      repeat (4) @(negedge clk_ref);
      settle_check($sformatf("sweep%0d", v));
    end

    // R9/R7/R8: bit latency and divider release on the RF loop
    pll_en_pin = 2'b11; pll_pd_bit = 2'b00; dbl_en = 1'b0;
    repeat (4) @(negedge clk_ref);
    pll_pd_bit[0] = 1'b1;
    @(negedge clk_ref);
    chk("R9 bit takes effect after one edge", cp_tri[0], 1'b1);
    chk("R7 resets rise with power-down", {r_cnt_rst[0], n_cnt_rst[0]}, 2'b11);
    pll_pd_bit[0] = 1'b0;
    @(negedge clk_ref);
    chk("R9 bit clear after one edge", cp_tri[0], 1'b0);
    chk("R8 resets held one more edge", {r_cnt_rst[0], n_cnt_rst[0]}, 2'b11);
    @(negedge clk_ref);
    chk("R8 resets fall together", {r_cnt_rst[0], n_cnt_rst[0]}, 2'b00);

    // R9: pin latency on the IF loop
    pll_en_pin[1] = 1'b0;
    repeat (2) @(negedge clk_ref);
    chk("R9 pin not yet effective after two edges", cp_tri[1], 1'b0);
    @(negedge clk_ref);
    chk("R9 pin effective on third edge", cp_tri[1], 1'b1);

    // R6/R9: pins low, doubler keeps oscillator alive, one-edge latency
    pll_en_pin = 2'b00; dbl_en = 1'b1;
    repeat (4) @(negedge clk_ref);
    chk("R6 doubler keeps oscillator on", osc_dis, 1'b0);
    dbl_en = 1'b0;
    @(negedge clk_ref);
    chk("R9 doubler clear after one edge", osc_dis, 1'b1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_ref);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule